// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero Insertion

This block turns a byte stream into a bit-oriented synchronous line stream. Frame bytes arrive on a valid/ready handshake with start and end markers. The framer sends them least significant bit first. After the last data byte it sends the frame check sequence supplied by an external CRC generator. Each frame sits between flag octets (0x7E, bit pattern 01111110). While no frame is pending the line carries flags back to back, so the flag that closes one frame can also open the next. Inside a frame, a 0 is inserted after every five consecutive 1 bits. This applies to the data bytes and to the check sequence. Flags and aborts are never stuffed.

A one-cycle abort request during a frame replaces the rest of that frame with eight 1 bits, and flag fill then resumes. The same abort is sent on its own if the upstream source fails to deliver the next byte of an unfinished frame in time. Bits leave on `tx_bit`, and `tx_stb` marks each bit slot. The bit rate is the clock rate divided by a parameter. Line encoding and the CRC arithmetic live outside the block.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is held, `in_ready` is 1 and `tx_stb` is 0. After reset the line carries back-to-back flags (0x7E). `tx_stb` is a one-cycle pulse that repeats every BIT_DIV clock cycles.
- R2: Every octet is sent bit 0 first. `tx_bit` is meaningful in the cycles where `tx_stb` is 1.
- R3: A frame goes out as a flag, then its data bytes in arrival order, then FCS_W/8 check bytes, then a flag. The check bytes come from `fcs_in`, least significant byte first. `fcs_in` is sampled once the last bit of the byte marked `in_eof` has been sent.
- R4: Within data and check bytes, a 0 is inserted after five consecutive 1 bits. The count of ones restarts on every sent 0, including an inserted 0. When the check field ends on five ones, the inserted 0 goes out before the closing flag.
- R5: No 0 is inserted while a flag or an abort octet is being sent.
- R6: A one-cycle `abort_req` while a data or check byte is being sent takes effect at the next bit slot. The block sends eight unstuffed 1 bits, discards any data byte it holds, and returns to flags. An `abort_req` while flags are being sent has no effect.
- R7: A data byte without `in_eof` may finish while no next byte is held. This underrun causes the same abort as R6.
- R8: When no frame is in progress, bytes with `in_sof` low are accepted and discarded. Such bytes produce no frame and do not disturb the flag stream.
- R9: A byte transfers in a cycle where `in_valid` and `in_ready` are both 1. There is a single holding register, so `in_ready` is 0 in the cycle after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Holding register free |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last data byte of a frame |
| abort_req | input | 1 | One-cycle request to abort the current frame |
| fcs_in | input | FCS_W | Check sequence computed over the frame's data bytes |
| tx_bit | output | 1 | Serial line bit |
| tx_stb | output | 1 | Marks a new bit on tx_bit |

## Verification
The assertions make few demands on the inputs, with two exceptions. `abort_req` must be a single-cycle pulse. `fcs_in` must be stable from the hand-over of the last data byte until the check field starts. The bench sets `fcs_in` before a frame and holds it until the decoded frame has come back. It pulses `abort_req` for one cycle only.

Outside the deliberate underrun case, the bench offers each byte with no more than one idle cycle before it. That gap is far shorter than a byte time at the chosen divider, so ordinary frames never starve. An independent de-stuffing receiver in the bench rebuilds frames, flags and aborts from `tx_bit`. Random byte values and check values are biased toward all-ones octets so that runs of five ones occur often, including at field boundaries.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DATA  = 2'd1,
        PH_FCS   = 2'd2,
        PH_ABORT = 2'd3
    } phase_e;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [7:0]  ABORT_OCTET = 8'hFF;
    localparam int unsigned RUN_LIMIT   = 5;
    localparam int unsigned OCTET_BITS  = 8;

endpackage

// File: rtl/hdlc_tx_pacer.sv
module hdlc_tx_pacer #(
    parameter int unsigned BIT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (BIT_DIV <= 1) begin : g_full_rate
            assign tick_o = 1'b1;
        end else begin : g_divided
            localparam int unsigned CW = $clog2(BIT_DIV);
            localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R1
        end
    endgenerate

endmodule

// File: rtl/hdlc_tx_zins.sv
module hdlc_tx_zins
    import hdlc_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic bit_i,
    input  logic count_i,
    output logic need_o
);

    logic [2:0] ones_d, ones_q;

    always_comb begin
        ones_d = ones_q;
        if (step_i) begin
            if (count_i && bit_i) ones_d = ones_q + 3'd1;
            else                  ones_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    assign need_o = (ones_q == 3'(RUN_LIMIT));

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= 3'(RUN_LIMIT)); // R4
    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && need_o) |-> !(count_i && bit_i)); // R4

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned BIT_DIV = 4,
    parameter int unsigned FCS_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             abort_req,
    input  logic [FCS_W-1:0] fcs_in,
    output logic             tx_bit,
    output logic             tx_stb
);

    localparam int unsigned FCS_BYTES = FCS_W / OCTET_BITS;
    localparam int unsigned FLW = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [7:0]       sh;
        logic [3:0]       left;
        logic             cur_eof;
        logic [FCS_W-1:0] fcs_sh;
        logic [FLW-1:0]   fcs_left;
        logic [7:0]       hold_data;
        logic             hold_v;
        logic             hold_sof;
        logic             hold_eof;
        logic             abort_pend;
        logic             tx_bit;
        logic             tx_stb;
    } fr_state_t;

    fr_state_t s_d, s_q;

    logic       tick;
    logic       need_stuff;
    phase_e     src_ph;
    logic [7:0] src_sh;
    logic [3:0] src_left;
    logic       in_frame;
    logic       abort_take;
    logic       stuff_now;
    logic       emit_bit;
    logic       emit_count;

    hdlc_tx_pacer #(.BIT_DIV(BIT_DIV)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    hdlc_tx_zins u_zins (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (tick),
        .bit_i   (emit_bit),
        .count_i (emit_count),
        .need_o  (need_stuff)
    );

    always_comb begin
        s_d        = s_q;
        in_frame   = (s_q.ph == PH_DATA) || (s_q.ph == PH_FCS);
        abort_take = tick && s_q.abort_pend && in_frame;
        src_ph     = s_q.ph;
        src_sh     = s_q.sh;
        src_left   = s_q.left;
        if (abort_take) begin
            src_ph   = PH_ABORT;
            src_sh   = ABORT_OCTET;
            src_left = 4'd8;
        end
        stuff_now  = tick && need_stuff && !abort_take;
        emit_bit   = 1'b0;
        emit_count = 1'b0;
        s_d.tx_stb = tick;
        if (tick) s_d.abort_pend = 1'b0;

        if (stuff_now) begin
            s_d.tx_bit = 1'b0;
        end else if (tick) begin
            emit_bit   = src_sh[0];
            emit_count = (src_ph == PH_DATA) || (src_ph == PH_FCS);
            s_d.tx_bit = src_sh[0];
            s_d.ph     = src_ph;
            s_d.sh     = {1'b0, src_sh[7:1]};
            s_d.left   = src_left - 4'd1;
            if (src_left == 4'd1) begin
                s_d.left = 4'd8;
                s_d.sh   = FLAG_OCTET;
                unique case (src_ph)
                    PH_IDLE: begin
                        if (s_q.hold_v && s_q.hold_sof) begin
                            s_d.sh      = s_q.hold_data;
                            s_d.cur_eof = s_q.hold_eof;
                            s_d.hold_v  = 1'b0;
                            s_d.ph      = PH_DATA;
                        end
                    end
                    PH_DATA: begin
                        if (s_q.cur_eof) begin
                            s_d.sh       = fcs_in[7:0];
                            s_d.fcs_sh   = fcs_in >> OCTET_BITS;
                            s_d.fcs_left = FLW'(FCS_BYTES - 1);
                            s_d.ph       = PH_FCS;
                        end else if (s_q.hold_v) begin
                            s_d.sh      = s_q.hold_data;
                            s_d.cur_eof = s_q.hold_eof;
                            s_d.hold_v  = 1'b0;
                        end else begin
                            s_d.sh = ABORT_OCTET;
                            s_d.ph = PH_ABORT;
                        end
                    end
                    PH_FCS: begin
                        if (s_q.fcs_left != '0) begin
                            s_d.sh       = s_q.fcs_sh[7:0];
                            s_d.fcs_sh   = s_q.fcs_sh >> OCTET_BITS;
                            s_d.fcs_left = s_q.fcs_left - 1'b1;
                        end else begin
                            s_d.ph = PH_IDLE;
                        end
                    end
                    PH_ABORT: begin
                        s_d.ph = PH_IDLE;
                    end
                endcase
            end
        end

        if ((s_d.ph == PH_IDLE || s_d.ph == PH_ABORT) && s_d.hold_v && !s_d.hold_sof)
            s_d.hold_v = 1'b0;

        if (in_valid && !s_q.hold_v) begin
            s_d.hold_v    = 1'b1;
            s_d.hold_data = in_data;
            s_d.hold_sof  = in_sof;
            s_d.hold_eof  = in_eof;
        end

        if (abort_req && in_frame && !abort_take) s_d.abort_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ph       <= PH_IDLE;
            s_q.sh       <= FLAG_OCTET;
            s_q.left     <= 4'd8;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.hold_v;
    assign tx_bit   = s_q.tx_bit;
    assign tx_stb   = s_q.tx_stb;

    AST_FCS_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_FCS && $past(s_q.ph) != PH_FCS) |-> $past(s_q.ph) == PH_DATA); // R3
    AST_ABORT_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.ph) == PH_ABORT && s_q.ph != PH_ABORT) |-> s_q.ph == PH_IDLE); // R6
    AST_TAKE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R9
    AST_IDLE_ABORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && !s_q.abort_pend) |=> !s_q.abort_pend || $past(abort_req) == 1'b0 || $past(s_q.ph) != PH_IDLE); // R6

endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 4;
    localparam int FCS_W      = 16;
    localparam logic [7:0] FLAGV = 8'h7E;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic             in_sof = 1'b0;
    logic             in_eof = 1'b0;
    logic             abort_req = 1'b0;
    logic [FCS_W-1:0] fcs_in = '0;
    logic             tx_bit;
    logic             tx_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_tx_framer #(.BIT_DIV(BIT_DIV), .FCS_W(FCS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .abort_req(abort_req),
        .fcs_in(fcs_in), .tx_bit(tx_bit), .tx_stb(tx_stb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // independent receiver
    int         ones = 0;
    bit         hunting = 1'b1;
    bit         bitbuf[$];
    logic [7:0] rx_bytes[$];
    int         rx_lens[$];
    int         rx_nfr = 0;
    int         rx_aborts = 0;
    int         rx_flags = 0;
    bit         raw[$];
    int         since = 0;
    int         n_strobes = 0;

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            if (ones == 7) begin
                rx_aborts++;
                hunting = 1'b1;
                bitbuf.delete();
            end
            if (ones < 7) bitbuf.push_back(1'b1);
        end else if (ones == 5) begin
            ones = 0;
        end else if (ones == 6) begin
            rx_flags++;
            repeat (7) if (bitbuf.size() > 0) void'(bitbuf.pop_back());
            if (!hunting && bitbuf.size() > 0) begin
                int len = bitbuf.size();
                if (len % 8 != 0) begin
                    rx_lens.push_back(-1);
                end else begin
                    for (int k = 0; k < len / 8; k++) begin
                        logic [7:0] v = '0;
                        for (int j = 0; j < 8; j++) v[j] = bitbuf[8*k + j];
                        rx_bytes.push_back(v);
                    end
                    rx_lens.push_back(len / 8);
                end
                rx_nfr++;
            end
            hunting = 1'b0;
            bitbuf.delete();
            ones = 0;
        end else begin
            ones = 0;
            bitbuf.push_back(1'b0);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            since = 0;
        end else begin
            since++;
            if (tx_stb) begin
                if (n_strobes > 0) check(since == BIT_DIV, "R1 strobe spacing", since, BIT_DIV);
                since = 0;
                n_strobes++;
                if (raw.size() < 32) raw.push_back(tx_bit);
                rx_bit(tx_bit);
            end
        end
    end

    logic [7:0] fb[0:15];

    function automatic logic [7:0] exp_byte(input int i, input int n, input logic [15:0] f);
        if (i < n) return fb[i];
        return (i == n) ? f[7:0] : f[15:8];
    endfunction

    function automatic logic flag_bit(input int i);
        return FLAGV[i % 8];
    endfunction

    task automatic drive_byte(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_rx(input int prev, output bit got);
        got = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (rx_nfr > prev) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic send_and_check(input int n, input logic [15:0] f, input string tag);
        int prev;
        int got_len;
        bit got;
        prev = rx_nfr;
        fcs_in = f;
        for (int i = 0; i < n; i++) begin
            drive_byte(fb[i], i == 0, i == n - 1);
            if (i == 0) check(in_ready == 1'b0, "R9 ready low while holding", int'(in_ready), 0);
        end
        wait_rx(prev, got);
        check(got, {tag, " R3 frame delivered"}, int'(got), 1);
        if (got) begin
            got_len = rx_lens.pop_front();
            check(got_len == n + 2, {tag, " R3 frame length"}, got_len, n + 2);
            for (int i = 0; i < got_len; i++) begin
                logic [7:0] g = rx_bytes.pop_front();
                if (got_len == n + 2)
                    check(g == exp_byte(i, n, f), {tag, " R2 R4 byte"}, int'(g), int'(exp_byte(i, n, f)));
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_junk;
        int pa;
        int pf;
        int pfl;
        seed_junk = $urandom(32'd7391);
        repeat (6) @(negedge clk);
        check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        check(tx_stb == 1'b0, "R1 reset tx_stb", int'(tx_stb), 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        for (int i = 0; i < 32; i++)
            check(raw[i] == flag_bit(i), "R1 R5 idle flag bit", int'(raw[i]), int'(flag_bit(i)));

        // R4: long runs of ones, FCS ending in ones before closing flag
        fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'hFF;
        send_and_check(3, 16'hFFFF, "all-ones");
        // R4 R5: flag-valued data must be stuffed
        fb[0] = 8'h7E; fb[1] = 8'h7E;
        send_and_check(2, 16'h7E7E, "flag-like");
        fb[0] = 8'h1F;
        send_and_check(1, 16'hF800, "single");
        fb[0] = 8'h00; fb[1] = 8'hF8; fb[2] = 8'h0F;
        send_and_check(3, 16'h3E01, "boundary");

        for (int r = 0; r < 12; r++) begin
            int n = 1 + int'($urandom % 8);
            logic [15:0] f = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
            for (int i = 0; i < n; i++) fb[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            send_and_check(n, f, "random");
        end

        // R6: abort in mid frame
        pa = rx_aborts; pf = rx_nfr;
        drive_byte(8'hA5, 1'b1, 1'b0);
        drive_byte(8'h3C, 1'b0, 1'b0);
        drive_byte(8'hC3, 1'b0, 1'b0);
        @(negedge clk) abort_req = 1'b1;
        @(negedge clk) abort_req = 1'b0;
        drive_byte(8'h11, 1'b0, 1'b0);
        drive_byte(8'h22, 1'b0, 1'b1);
        repeat (400) @(negedge clk);
        check(rx_aborts == pa + 1, "R6 abort sent", rx_aborts, pa + 1);
        check(rx_nfr == pf, "R6 R8 no frame after abort", rx_nfr, pf);
        fb[0] = 8'h96; fb[1] = 8'hFF;
        send_and_check(2, 16'h1234, "after-abort R6");

        // R7: underrun
        pa = rx_aborts; pf = rx_nfr;
        drive_byte(8'h5A, 1'b1, 1'b0);
        repeat (400) @(negedge clk);
        check(rx_aborts == pa + 1, "R7 underrun abort", rx_aborts, pa + 1);
        check(rx_nfr == pf, "R7 no frame on underrun", rx_nfr, pf);
        fb[0] = 8'hC0; fb[1] = 8'h3F; fb[2] = 8'hE7;
        send_and_check(3, 16'hFC3F, "after-underrun R7");

        // R6: abort request while idle ignored
        repeat (100) @(negedge clk);
        pa = rx_aborts; pfl = rx_flags;
        @(negedge clk) abort_req = 1'b1;
        @(negedge clk) abort_req = 1'b0;
        repeat (400) @(negedge clk);
        check(rx_aborts == pa, "R6 idle abort ignored", rx_aborts, pa);
        check(rx_flags >= pfl + 10, "R6 flags continue", rx_flags, pfl + 10);

        // R8: stray bytes in idle discarded
        pf = rx_nfr; pfl = rx_flags;
        drive_byte(8'h81, 1'b0, 1'b0);
        drive_byte(8'h42, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        check(rx_nfr == pf, "R8 stray bytes dropped", rx_nfr, pf);
        check(rx_flags >= pfl + 4, "R8 flag fill kept", rx_flags, pfl + 4);
        fb[0] = 8'h55;
        send_and_check(1, 16'hAAAA, "after-stray R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule